// File: doc/BRIEF.md
# SPI Master Chip-Select Sequencer

This block decides when an SPI master starts each word and when its chip-select lines go active and inactive. Software writes a 32-bit transmit register. The upper half carries the word's control: a hold flag, a word-delay enable, a format select and a chip-select mask. The lower half carries the 16-bit data. A data write marks the transmit buffer full. The sequencer then starts a word only from idle, or once the gap or delay required by the previous word has run out.

After each word, chip-select either stays active (hold) or is released. Release waits for a programmable end-of-transfer delay and is followed by a guaranteed inactive gap. When the next word keeps the same mask, a held line stays low through that word. A different mask releases the old pins first. An optional per-format word delay holds off the next start. A write that touches only the control half never starts a word, so the format output can be changed ahead of the data. In slave mode the hold and delay flags have no effect. A small mode-0 shift engine, MSB first, sends each word and reports completion with a one-cycle pulse.

Top module: `spi_cs_sequencer`

## Requirements
- R1: After reset every chip-select output is high, the serial clock is low, the read-back value is zero and the done pulse is low.
- R2: The read-back places hold at bit 28, word-delay enable at bit 26, format at bits 25:24, mask at bits 23:16 and data at bits 15:0. Bits 31:29 and bit 27 always read 0.
- R3: Mask bits at or above NUM_CS are stored as 0; with 6 pins, writing FFh to the mask reads back 3Fh.
- R4: A write with only the control strobe (wr_strobe=2'b10) starts no word: chip-select stays high and the clock stays low. fmt_sel follows the written format within two cycles while the sequencer is idle.
- R5: A write with the data strobe (wr_strobe bit 0) starts a word. Pin i goes low exactly when mask bit i is 1, the word is shifted out MSB first, and xfer_done pulses with the received word on rx_data.
- R6: With hold 0, chip-select stays active for at least 256 − t2c_delay cycles after xfer_done before it goes high.
- R7: With hold 0, a pin that rises stays high for at least 2 cycles, even when the next word with the same mask is already waiting.
- R8: With hold 1, chip-select stays active after the word until a new data write. If the new mask equals the held one, no pin goes high before or during that next word.
- R9: With hold 1, a new word whose mask differs releases all pins for at least 2 cycles before the new mask asserts.
- R10: With word-delay enable 1 and hold 0, the next word starts no sooner than 256 − word_delay[format] cycles after the release gap, so chip-select stays high for at least that count plus 2 cycles. The 8-bit field of word_delay at bits 8·f+7:8·f belongs to format f.
- R11: With master_mode 0, hold and word-delay enable are ignored: chip-select is released after the end-of-transfer delay even when hold is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1 = master; 0 = slave, hold and delay ignored |
| wr_en | input | 1 | Register write enable |
| wr_strobe | input | 2 | Bit 1 writes the control half, bit 0 writes the data half |
| wr_data | input | 32 | Register write value |
| t2c_delay | input | 8 | Start value of the end-of-transfer to release counter |
| word_delay | input | 32 | Four 8-bit word-delay start values, one per format |
| miso | input | 1 | Serial data in |
| rd_data | output | 32 | Register read-back |
| cs_n | output | NUM_CS | Active-low chip-select pins |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| fmt_sel | output | 2 | Format in effect, for the clock generator |
| rx_data | output | 16 | Last received word |
| xfer_done | output | 1 | One-cycle pulse at the end of each word |

## Verification
The hardest state to reach from the ports is a held chip-select when a new word arrives. With the same mask, the line must stay low across the word boundary. With a different mask, the line must drop out cleanly. The bench sends a word with hold set, waits for it to finish, and checks the line during a long idle stretch. It then writes the next word with the same mask, or a different one, and counts every cycle in which the pins are all high. The second hard case is a back-to-back release with the buffer already full. The bench writes the second word as soon as the first has asserted chip-select. It then measures the inactive gap, with and without a per-format word delay.

// File: rtl/spi_cs_seq_pkg.sv
package spi_cs_seq_pkg;
  localparam int REG_W    = 32;
  localparam int TX_W     = 16;
  localparam int FMT_W    = 2;
  localparam int NUM_FMT  = 1 << FMT_W;
  localparam int CSF_W    = 8;
  localparam int HOLD_BIT = 28;
  localparam int WDEL_BIT = 26;
  localparam int FMT_LSB  = 24;
  localparam int CS_LSB   = 16;

  typedef struct packed {
    logic             hold;
    logic             wdel;
    logic [FMT_W-1:0] fmt;
    logic [CSF_W-1:0] cs;
  } word_ctrl_t;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_SHIFT,
    SEQ_T2C,
    SEQ_GAP,
    SEQ_WDEL,
    SEQ_HOLD
  } seq_state_e;
endpackage

// File: rtl/spi_txctl_reg.sv
module spi_txctl_reg
  import spi_cs_seq_pkg::*;
#(
  parameter int NUM_CS = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_strobe,
  input  logic [REG_W-1:0] wr_data,
  input  logic             consume,
  output word_ctrl_t       ctrl_o,
  output logic [TX_W-1:0]  txdata_o,
  output logic             full_o,
  output logic [REG_W-1:0] rd_data_o
);
  localparam logic [CSF_W-1:0] CS_KEEP = CSF_W'((16'd1 << NUM_CS) - 16'd1);
  localparam int               HI_W    = REG_W - TX_W;
  localparam logic [HI_W-1:0]  HI_KEEP =
    (HI_W'(1) << (HOLD_BIT - TX_W)) |
    (HI_W'(1) << (WDEL_BIT - TX_W)) |
    (HI_W'(NUM_FMT - 1) << (FMT_LSB - TX_W)) |
    (HI_W'(CS_KEEP) << (CS_LSB - TX_W));

  logic [HI_W-1:0] hi_q;
  logic [TX_W-1:0] lo_q;
  logic            full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      lo_q   <= '0;
      full_q <= 1'b0;
    end else begin
      if (wr_en && wr_strobe[1]) hi_q <= wr_data[REG_W-1:TX_W] & HI_KEEP;
      if (wr_en && wr_strobe[0]) lo_q <= wr_data[TX_W-1:0];
      if (wr_en && wr_strobe[0]) full_q <= 1'b1;
      else if (consume)          full_q <= 1'b0;
    end
  end

  assign ctrl_o.hold = hi_q[HOLD_BIT-TX_W];
  assign ctrl_o.wdel = hi_q[WDEL_BIT-TX_W];
  assign ctrl_o.fmt  = hi_q[FMT_LSB-TX_W +: FMT_W];
  assign ctrl_o.cs   = hi_q[CS_LSB-TX_W +: CSF_W];
  assign txdata_o    = lo_q;
  assign full_o      = full_q;
  assign rd_data_o   = {hi_q, lo_q};
endmodule

// File: rtl/spi_gap_timer.sv
module spi_gap_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  output logic             expired
);
  localparam logic [DLY_W-1:0] TOP = {DLY_W{1'b1}};

  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= TOP;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == TOP);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DATA_W  = 16,
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);
  localparam int              DIV_W     = $clog2(CLK_DIV + 1);
  localparam int              EDGE_W    = $clog2(2 * DATA_W + 1);
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(CLK_DIV - 1);
  localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(2 * DATA_W - 1);

  logic              active_q;
  logic [DIV_W-1:0]  div_q;
  logic [EDGE_W-1:0] edge_q;
  logic [DATA_W-1:0] tx_sh_q;
  logic [DATA_W-1:0] rx_sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      div_q    <= '0;
      edge_q   <= '0;
      sclk     <= 1'b0;
      tx_sh_q  <= '0;
      rx_sh_q  <= '0;
      done     <= 1'b0;
      rx_word  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active_q <= 1'b1;
        tx_sh_q  <= tx_word;
        div_q    <= '0;
        edge_q   <= '0;
        sclk     <= 1'b0;
      end else if (active_q) begin
        if (div_q == DIV_LAST) begin
          div_q  <= '0;
          sclk   <= ~sclk;
          edge_q <= edge_q + 1'b1;
          if (!sclk) rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso};
          else       tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
          if (edge_q == EDGE_LAST) begin
            active_q <= 1'b0;
            done     <= 1'b1;
            rx_word  <= rx_sh_q;
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign mosi = tx_sh_q[DATA_W-1];
endmodule

// File: rtl/spi_cs_fsm.sv
module spi_cs_fsm
  import spi_cs_seq_pkg::*;
#(
  parameter int NUM_CS  = 6,
  parameter int DLY_W   = 8,
  parameter int MIN_GAP = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     master_mode,
  input  logic                     buf_full,
  input  word_ctrl_t               ctrl_in,
  input  logic [TX_W-1:0]          tx_in,
  input  logic                     eng_done,
  input  logic [DLY_W-1:0]         t2c_dly,
  input  logic [NUM_FMT*DLY_W-1:0] wdel_dly,
  input  logic                     tmr_expired,
  output logic                     consume,
  output logic                     tmr_load,
  output logic [DLY_W-1:0]         tmr_val,
  output logic [NUM_CS-1:0]        cs_n,
  output logic                     eng_start,
  output logic [TX_W-1:0]          eng_data,
  output logic [FMT_W-1:0]         fmt_sel,
  output seq_state_e               state_o
);
  localparam logic [DLY_W-1:0] GAP_LOAD = {DLY_W{1'b1}} - DLY_W'(MIN_GAP - 1);

  seq_state_e       state_q, state_d;
  word_ctrl_t       cur_q;
  logic             wpend_q, wpend_d;
  logic             do_start, do_release;
  logic [DLY_W-1:0] wsel;

  assign wsel = wdel_dly[int'(cur_q.fmt) * DLY_W +: DLY_W];

  always_comb begin
    state_d    = state_q;
    wpend_d    = wpend_q;
    do_start   = 1'b0;
    do_release = 1'b0;
    tmr_load   = 1'b0;
    tmr_val    = t2c_dly;
    unique case (state_q)
      SEQ_IDLE: begin
        if (buf_full) begin
          do_start = 1'b1;
          state_d  = SEQ_SHIFT;
        end
      end
      SEQ_SHIFT: begin
        if (eng_done) begin
          if (cur_q.hold) begin
            if (cur_q.wdel) begin
              tmr_load = 1'b1;
              tmr_val  = wsel;
              state_d  = SEQ_WDEL;
            end else begin
              state_d  = SEQ_HOLD;
            end
          end else begin
            tmr_load = 1'b1;
            tmr_val  = t2c_dly;
            wpend_d  = cur_q.wdel;
            state_d  = SEQ_T2C;
          end
        end
      end
      SEQ_T2C: begin
        if (tmr_expired) begin
          do_release = 1'b1;
          tmr_load   = 1'b1;
          tmr_val    = GAP_LOAD;
          state_d    = SEQ_GAP;
        end
      end
      SEQ_GAP: begin
        if (tmr_expired) begin
          if (wpend_q) begin
            tmr_load = 1'b1;
            tmr_val  = wsel;
            wpend_d  = 1'b0;
            state_d  = SEQ_WDEL;
          end else begin
            state_d  = SEQ_IDLE;
          end
        end
      end
      SEQ_WDEL: begin
        if (tmr_expired) state_d = cur_q.hold ? SEQ_HOLD : SEQ_IDLE;
      end
      SEQ_HOLD: begin
        if (buf_full) begin
          if (ctrl_in.cs == cur_q.cs) begin
            do_start = 1'b1;
            state_d  = SEQ_SHIFT;
          end else begin
            do_release = 1'b1;
            tmr_load   = 1'b1;
            tmr_val    = GAP_LOAD;
            state_d    = SEQ_GAP;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SEQ_IDLE;
      wpend_q   <= 1'b0;
      cur_q     <= '0;
      cs_n      <= '1;
      eng_start <= 1'b0;
      eng_data  <= '0;
      fmt_sel   <= '0;
    end else begin
      state_q   <= state_d;
      wpend_q   <= wpend_d;
      eng_start <= do_start;
      fmt_sel   <= (state_q == SEQ_IDLE) ? ctrl_in.fmt : cur_q.fmt;
      if (do_start) begin
        cur_q.hold <= ctrl_in.hold & master_mode;
        cur_q.wdel <= ctrl_in.wdel & master_mode;
        cur_q.fmt  <= ctrl_in.fmt;
        cur_q.cs   <= ctrl_in.cs;
        eng_data   <= tx_in;
        cs_n       <= ~ctrl_in.cs[NUM_CS-1:0];
      end else if (do_release) begin
        cs_n <= '1;
      end
    end
  end

  assign consume = do_start;
  assign state_o = state_q;
endmodule

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer
  import spi_cs_seq_pkg::*;
#(
  parameter int NUM_CS  = 6,
  parameter int CLK_DIV = 2,
  parameter int DLY_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     master_mode,
  input  logic                     wr_en,
  input  logic [1:0]               wr_strobe,
  input  logic [REG_W-1:0]         wr_data,
  input  logic [DLY_W-1:0]         t2c_delay,
  input  logic [NUM_FMT*DLY_W-1:0] word_delay,
  input  logic                     miso,
  output logic [REG_W-1:0]         rd_data,
  output logic [NUM_CS-1:0]        cs_n,
  output logic                     sclk,
  output logic                     mosi,
  output logic [FMT_W-1:0]         fmt_sel,
  output logic [TX_W-1:0]          rx_data,
  output logic                     xfer_done
);
  word_ctrl_t       ctrl_w;
  logic [TX_W-1:0]  txdata_w;
  logic             buf_full_w;
  logic             consume_w;
  logic             tmr_load_w;
  logic [DLY_W-1:0] tmr_val_w;
  logic             tmr_exp_w;
  logic             eng_start_w;
  logic [TX_W-1:0]  eng_data_w;
  seq_state_e       state_w;
  logic             in_shift_w;
  logic             in_hold_w;

  spi_txctl_reg #(.NUM_CS(NUM_CS)) reg_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_strobe(wr_strobe),
    .wr_data(wr_data), .consume(consume_w), .ctrl_o(ctrl_w),
    .txdata_o(txdata_w), .full_o(buf_full_w), .rd_data_o(rd_data)
  );

  spi_gap_timer #(.DLY_W(DLY_W)) tmr_i (
    .clk(clk), .rst(rst), .load(tmr_load_w), .load_val(tmr_val_w),
    .expired(tmr_exp_w)
  );

  spi_cs_fsm #(.NUM_CS(NUM_CS), .DLY_W(DLY_W)) fsm_i (
    .clk(clk), .rst(rst), .master_mode(master_mode), .buf_full(buf_full_w),
    .ctrl_in(ctrl_w), .tx_in(txdata_w), .eng_done(xfer_done),
    .t2c_dly(t2c_delay), .wdel_dly(word_delay), .tmr_expired(tmr_exp_w),
    .consume(consume_w), .tmr_load(tmr_load_w), .tmr_val(tmr_val_w),
    .cs_n(cs_n), .eng_start(eng_start_w), .eng_data(eng_data_w),
    .fmt_sel(fmt_sel), .state_o(state_w)
  );

  spi_shift_engine #(.DATA_W(TX_W), .CLK_DIV(CLK_DIV)) eng_i (
    .clk(clk), .rst(rst), .start(eng_start_w), .tx_word(eng_data_w),
    .miso(miso), .sclk(sclk), .mosi(mosi), .done(xfer_done),
    .rx_word(rx_data)
  );

  assign in_shift_w = (state_w == SEQ_SHIFT);
  assign in_hold_w  = (state_w == SEQ_HOLD);
endmodule

// File: rtl/spi_cs_seq_chk.sv
module spi_cs_seq_chk #(
  parameter int NUM_CS = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CS-1:0] cs_n,
  input logic              sclk,
  input logic [31:0]       rd_data,
  input logic              seq_start,
  input logic              buf_full,
  input logic              in_shift,
  input logic              in_hold
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((&cs_n) && !sclk));

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_data[31:29] == 3'b000) && !rd_data[27]);

  assert_cs_trim_R3: assert property (@(posedge clk) disable iff (rst)
    ((rd_data[23:16] >> NUM_CS) == 8'h00));

  assert_start_needs_data_R4: assert property (@(posedge clk) disable iff (rst)
    seq_start |-> $past(buf_full));

  assert_sclk_in_word_R5: assert property (@(posedge clk) disable iff (rst)
    sclk |-> in_shift);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_pin
    assert_min_gap_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(cs_n[i]) |=> cs_n[i]);
  end

  assert_hold_steady_R8: assert property (@(posedge clk) disable iff (rst)
    (in_hold && $past(in_hold)) |-> $stable(cs_n));
endmodule

bind spi_cs_sequencer spi_cs_seq_chk #(.NUM_CS(NUM_CS)) chk_i (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .rd_data(rd_data),
  .seq_start(eng_start_w), .buf_full(buf_full_w),
  .in_shift(in_shift_w), .in_hold(in_hold_w)
);

// File: tb/spi_cs_sequencer_tb.sv
module spi_cs_sequencer_tb_top;
  localparam int NUM_CS = 6;
  localparam logic [NUM_CS-1:0] ALL1 = '1;
  localparam int T2C = 250;
  localparam int LIMIT = 3000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        master_mode = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_strobe = 2'b00;
  logic [31:0] wr_data = '0;
  logic [7:0]  t2c_delay = 8'(T2C);
  logic [31:0] word_delay = {8'd240, 8'd236, 8'd230, 8'd250};
  logic        miso;
  logic [31:0] rd_data;
  logic [NUM_CS-1:0] cs_n;
  logic        sclk, mosi, xfer_done;
  logic [1:0]  fmt_sel;
  logic [15:0] rx_data;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;
  assign miso = mosi;

  spi_cs_sequencer #(.NUM_CS(NUM_CS)) dut_i (
    .clk(clk), .rst(rst), .master_mode(master_mode), .wr_en(wr_en),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .t2c_delay(t2c_delay),
    .word_delay(word_delay), .miso(miso), .rd_data(rd_data), .cs_n(cs_n),
    .sclk(sclk), .mosi(mosi), .fmt_sel(fmt_sel), .rx_data(rx_data),
    .xfer_done(xfer_done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] stb, input logic [31:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_strobe = stb; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0; wr_strobe = 2'b00;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!xfer_done && n < LIMIT) begin @(negedge clk); n++; end
    check(xfer_done, req, 32'(n), LIMIT);
  endtask

  task automatic wait_cs(input bit want_high, input string req);
    int n = 0;
    while (((cs_n == ALL1) != want_high) && n < LIMIT) begin @(negedge clk); n++; end
    check((cs_n == ALL1) == want_high, req, 32'(cs_n), 32'(want_high));
  endtask

  task automatic count_high(output int n);
    n = 0;
    while (cs_n == ALL1 && n < LIMIT) begin @(negedge clk); n++; end
  endtask

  task automatic settle();
    wait_cs(1'b1, "settle");
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(cs_n == ALL1, "R1 cs_n", 32'(cs_n), 32'(ALL1));
    check(!sclk && !xfer_done, "R1 sclk/done", {sclk, xfer_done}, 0);
    check(rd_data == 32'h0, "R1 rd_data", rd_data, 0);
  endtask

  task automatic t_regmap();
    bit moved = 0;
    wr(2'b10, 32'hFFFF_FFFF);
    check(rd_data == 32'h173F_0000, "R2 field map/reserved", rd_data, 32'h173F_0000);
    check(rd_data[23:16] == 8'h3F, "R3 mask trim", rd_data[23:16], 8'h3F);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cs_n != ALL1 || sclk) moved = 1;
    end
    check(!moved, "R4 no start on control write", 32'(moved), 0);
    check(fmt_sel == 2'd3, "R4 fmt_sel", fmt_sel, 3);
    wr(2'b10, 32'h0100_0000);
    repeat (2) @(negedge clk);
    check(fmt_sel == 2'd1, "R4 fmt_sel update", fmt_sel, 1);
    check(cs_n == ALL1, "R4 still idle", 32'(cs_n), 32'(ALL1));
  endtask

  task automatic t_basic();
    int n = 0;
    wr(2'b11, 32'h0005_A5C3);
    wait_cs(1'b0, "R5 start");
    check(cs_n == 6'h3A, "R5 mask pins", 32'(cs_n), 6'h3A);
    wait_done("R5 done");
    check(rx_data == 16'hA5C3, "R5 rx loopback", rx_data, 16'hA5C3);
    @(negedge clk);
    while (cs_n != ALL1 && n < LIMIT) begin n++; @(negedge clk); end
    check(n >= 256 - T2C, "R6 release delay", 32'(n), 256 - T2C);
    settle();
  endtask

  task automatic t_back2back();
    int n;
    wr(2'b11, 32'h0005_1111);
    wait_cs(1'b0, "R7 first start");
    wr(2'b11, 32'h0005_2222);
    wait_done("R7 first done");
    wait_cs(1'b1, "R7 release");
    count_high(n);
    check(n >= 2 && n < 10, "R7 min gap", 32'(n), 2);
    check(cs_n == 6'h3A, "R7 reassert", 32'(cs_n), 6'h3A);
    wait_done("R7 second done");
    check(rx_data == 16'h2222, "R7 second word", rx_data, 16'h2222);
    settle();
  endtask

  task automatic t_hold_same();
    int highs = 0;
    wr(2'b11, 32'h1005_1234);
    wait_done("R8 first done");
    repeat (30) @(negedge clk);
    check(cs_n == 6'h3A, "R8 held after word", 32'(cs_n), 6'h3A);
    wr(2'b11, 32'h0005_5678);
    for (int i = 0; i < LIMIT && !xfer_done; i++) begin
      if (cs_n == ALL1) highs++;
      @(negedge clk);
    end
    check(highs == 0, "R8 no release across words", 32'(highs), 0);
    check(rx_data == 16'h5678, "R8 second word", rx_data, 16'h5678);
    wait_cs(1'b1, "R8 released after hold cleared");
    settle();
  endtask

  task automatic t_hold_change();
    int n;
    wr(2'b11, 32'h1005_0F0F);
    wait_done("R9 first done");
    repeat (10) @(negedge clk);
    check(cs_n == 6'h3A, "R9 held", 32'(cs_n), 6'h3A);
    wr(2'b11, 32'h000A_F0F0);
    wait_cs(1'b1, "R9 old mask released");
    count_high(n);
    check(n >= 2, "R9 gap before new mask", 32'(n), 2);
    check(cs_n == 6'h35, "R9 new mask", 32'(cs_n), 6'h35);
    wait_done("R9 second done");
    settle();
  endtask

  task automatic t_wdel();
    int n;
    wr(2'b11, 32'h0605_3C3C);
    wait_cs(1'b0, "R10 first start");
    wr(2'b11, 32'h0605_C3C3);
    wait_done("R10 first done");
    wait_cs(1'b1, "R10 release");
    count_high(n);
    check(n >= (256 - 236) + 2, "R10 format 2 word delay", 32'(n), 22);
    check(n < 40, "R10 delay bounded", 32'(n), 40);
    wait_done("R10 second done");
    settle();
  endtask

  task automatic t_slave();
    int n = 0;
    master_mode = 1'b0;
    wr(2'b11, 32'h1405_7E7E);
    wait_done("R11 done");
    @(negedge clk);
    while (cs_n != ALL1 && n < 200) begin n++; @(negedge clk); end
    check(n >= 256 - T2C && n <= 12, "R11 hold ignored", 32'(n), 256 - T2C);
    settle();
    master_mode = 1'b1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regmap();
    t_basic();
    t_back2back();
    t_hold_same();
    t_hold_change();
    t_wdel();
    t_slave();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule